// File: doc/BRIEF.md
# Sine Table Sequencer with Switchable Step Rate

This block produces an 8-bit digitally coded sine wave for a parallel DAC. A phase address steps through a table of one full sine cycle, held in the block as offset-binary codes. Each step presents the next code on the DAC port, and the sequence runs without a pause. The address is a plain counter, not a phase accumulator. The output frequency therefore depends only on how often the counter advances.

The step rate comes from a clock-enable divider running on the single system clock. A two-bit select input picks one of three preset terminal counts. By default these give 60 Hz, 400 Hz and 1000 Hz sine outputs from a 200 MHz clock. When the select changes, the divider compares its running count against the new terminal count, so the new rate applies from the next step. The phase address is never reset or skipped on a change, so the waveform continues without a jump.

The sample code, its table index and a one-cycle load strobe all leave the block from registers, ready to latch into a DAC.

Top module: `sine_table_seq`

## Requirements
- R1: A synchronous active-high reset sets `phase` to 0, `dac_code` to 128 (mid-scale) and `dac_load` low. After the last reset edge, the first load arrives at the (T+1)-th clock edge, where T is the selected terminal count.
- R2: The code at table index i is 128 + round(127 * sin(2*pi*i/256)), rounded half away from zero. This gives 128 at index 0, 255 at index 64, 128 at index 128 and 1 at index 192. `dac_code` always equals the table code of the index shown on `phase`.
- R3: Each cycle with `dac_load` high shows `phase` one greater than its previous value, wrapping from 255 to 0. In cycles with `dac_load` low, `phase` and `dac_code` hold their values.
- R4: With `rate_sel` = 2'b00, loads repeat every TC_A cycles. With 2'b01 they repeat every TC_B cycles, and with 2'b10 every TC_C cycles.
- R5: `rate_sel` = 2'b11 selects the same step rate as 2'b00.
- R6: A change of `rate_sel` never resets, repeats or skips the phase. The next load after the change shows the following index.
- R7: The divider counts the cycles since the last step. Let c be that count at the moment `rate_sel` changes to a rate with terminal count T. If c >= T-1, the step comes at the next clock edge. Otherwise it comes after T-1-c further cycles. In both cases the load follows one cycle after the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Step rate select: 00 rate A, 01 rate B, 10 rate C, 11 rate A |
| dac_code | output | 8 | Offset-binary sine code for the DAC |
| dac_load | output | 1 | One-cycle strobe that marks a new code on `dac_code` |
| phase | output | 8 | Table index of the code shown on `dac_code` |

## Verification
The assertions take the following as given:
- Every terminal count is at least 1.
- `rate_sel` is synchronous to `clk`.
- Reset is applied once before the outputs carry meaning, so the phase-step and hold properties are armed only after one clean cycle out of reset.

The stimulus meets these conditions. It changes `rate_sel` and `rst` only on the falling clock edge and starts every run with a reset. The bench uses small terminal counts (9, 4 and 2 cycles), so a full 256-step wrap and mid-interval rate switches both fit in a short run.

// File: rtl/sts_pkg.sv
package sts_pkg;

  // Rate select encoding; the fourth code aliases rate A.
  typedef enum logic [1:0] {
    RATE_A     = 2'b00,
    RATE_B     = 2'b01,
    RATE_C     = 2'b10,
    RATE_A_ALT = 2'b11
  } rate_e;

  // Offset-binary sine sample: mid-scale plus rounded amplitude term.
  function automatic int sine_code(input int idx, input int depth, input int code_w);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(depth);
    v = real'(2 ** (code_w - 1)) + real'(2 ** (code_w - 1) - 1) * $sin(ang);
    return $rtoi($floor(v + 0.5));
  endfunction

endpackage

// File: rtl/sts_rate_div.sv
module sts_rate_div #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] term,
  output logic             step
);

  logic [CNT_W-1:0] cnt_q;

  // Reaching or passing the terminal count fires a step, so a switch to a
  // shorter count never waits for the counter to roll over.
  assign step = ({1'b0, cnt_q} + 1'b1) >= {1'b0, term};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sts_sine_rom.sv
module sts_sine_rom
  import sts_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(2 ** (CODE_W - 1));

  logic [CODE_W-1:0] mem [DEPTH];

  // Table contents are computed at elaboration; read port is registered.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = CODE_W'(sine_code(i, DEPTH, CODE_W));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= MID_CODE;
    end else begin
      code <= mem[addr];
    end
  end

endmodule

// File: rtl/sine_table_seq.sv
module sine_table_seq
  import sts_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int FREQ_A = 60,
  parameter int FREQ_B = 400,
  parameter int FREQ_C = 1000,
  parameter int DEPTH  = 256,
  parameter int CODE_W = 8,
  parameter int TC_A   = CLK_HZ / (FREQ_A * DEPTH),
  parameter int TC_B   = CLK_HZ / (FREQ_B * DEPTH),
  parameter int TC_C   = CLK_HZ / (FREQ_C * DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 rate_sel,
  output logic [CODE_W-1:0]          dac_code,
  output logic                       dac_load,
  output logic [$clog2(DEPTH)-1:0]   phase
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int TC_AB  = (TC_A > TC_B) ? TC_A : TC_B;
  localparam int TC_MAX = (TC_AB > TC_C) ? TC_AB : TC_C;
  localparam int CNT_W  = $clog2(TC_MAX + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [CNT_W-1:0]  term;
  logic              step;
  logic              step_d;
  logic [ADDR_W-1:0] addr_q;

  // Terminal count lookup; the alias code falls back to rate A.
  always_comb begin
    case (rate_e'(rate_sel))
      RATE_B:  term = CNT_W'(TC_B);
      RATE_C:  term = CNT_W'(TC_C);
      default: term = CNT_W'(TC_A);
    endcase
  end

  sts_rate_div #(
    .CNT_W (CNT_W)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .term (term),
    .step (step)
  );

  // Phase address: advances only on a step and is never cleared by a rate change.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      step_d <= 1'b0;
    end else begin
      step_d <= step;
      if (step) begin
        addr_q <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
      end
    end
  end

  sts_sine_rom #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W)
  ) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (addr_q),
    .code (dac_code)
  );

  // Index and strobe are aligned with the registered table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      dac_load <= 1'b0;
    end else begin
      phase    <= addr_q;
      dac_load <= step_d;
    end
  end

endmodule

// File: rtl/sts_checker.sv
module sts_checker #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  parameter int CODE_W = 8,
  parameter int TC_MAX = 13020
) (
  input logic              clk,
  input logic              rst,
  input logic              dac_load,
  input logic [ADDR_W-1:0] phase,
  input logic [CODE_W-1:0] dac_code
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(2 ** (CODE_W - 1));
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(2 ** CODE_W - 1);
  localparam logic [CODE_W-1:0] BOT_CODE = CODE_W'(1);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  logic armed = 1'b0;
  int   gap   = 0;

  always_ff @(posedge clk) begin
    armed <= !rst;
    if (rst || dac_load) begin
      gap <= 0;
    end else begin
      gap <= gap + 1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phase == '0 && dac_code == MID_CODE && !dac_load));

  assert_table_points_R2: assert property (@(posedge clk) disable iff (rst)
    ((phase == '0) |-> dac_code == MID_CODE) and
    ((phase == ADDR_W'(DEPTH / 4)) |-> dac_code == TOP_CODE) and
    ((phase == ADDR_W'(3 * DEPTH / 4)) |-> dac_code == BOT_CODE));

  // R3 and R6: each load advances the index by one, whatever the rate does.
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    dac_load |-> phase == (($past(phase) == LAST_IDX) ? '0 : $past(phase) + 1'b1));

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    !dac_load |-> ($stable(phase) && $stable(dac_code)));

  assert_gap_bound_R4: assert property (@(posedge clk) disable iff (rst)
    gap <= TC_MAX + 1);

endmodule

bind sine_table_seq sts_checker #(
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W),
  .CODE_W (CODE_W),
  .TC_MAX (TC_MAX)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dac_load (dac_load),
  .phase    (phase),
  .dac_code (dac_code)
);

// File: tb/tb_sine_table_seq.sv
module tb_sine_table_seq;

  localparam int T_A = 9;
  localparam int T_B = 4;
  localparam int T_C = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_sel = 2'b00;
  logic [7:0] dac_code;
  logic       dac_load;
  logic [7:0] phase;

  int n_run  = 0;
  int n_fail = 0;
  int held_phase = 0;
  int held_code  = 128;

  always #2.5 clk = ~clk;

  sine_table_seq #(
    .DEPTH (256), .CODE_W (8), .TC_A (T_A), .TC_B (T_B), .TC_C (T_C)
  ) dut (
    .clk (clk), .rst (rst), .rate_sel (rate_sel),
    .dac_code (dac_code), .dac_load (dac_load), .phase (phase)
  );

  // Vector table: select, number of loads to observe, expected load period.
  localparam int NV = 6;
  localparam logic [1:0] V_SEL [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b10, 2'b01};
  localparam int         V_CNT [NV] = '{6, 8, 10, 6, 260, 5};
  localparam int         V_TC  [NV] = '{T_A, T_B, T_C, T_A, T_C, T_B};

  function automatic int exp_code(input int i);
    real s;
    s = 127.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 256.0);
    return 128 + $rtoi($floor(s + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to the next load; R3 hold behaviour is watched on the way.
  task automatic wait_load(output int gap);
    bit held_ok;
    held_ok = 1'b1;
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (!dac_load && (int'(phase) != held_phase || int'(dac_code) != held_code))
        held_ok = 1'b0;
    end while (!dac_load && gap < 20000);
    check(held_ok, "R3 hold between loads", int'(phase), held_phase);
  endtask

  task automatic check_load(input string req);
    int nxt;
    nxt = (held_phase + 1) % 256;
    check(int'(phase) == nxt, {req, " phase step"}, int'(phase), nxt);
    check(int'(dac_code) == exp_code(int'(phase)), "R2 code", int'(dac_code),
          exp_code(int'(phase)));
    held_phase = int'(phase);
    held_code  = int'(dac_code);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int gap;
    string tag;
    // R1: reset state, then first load timing from reset release.
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(phase == 8'd0, "R1 phase", int'(phase), 0);
    check(dac_code == 8'd128, "R1 code", int'(dac_code), 128);
    check(dac_load == 1'b0, "R1 load", int'(dac_load), 0);
    wait_load(gap);
    check(gap == T_A + 1, "R1 first load", gap, T_A + 1);
    check_load("R1");

    // Vector loop: R4 periods, R5 alias, R6 continuity, R2 codes incl. wrap.
    for (int v = 0; v < NV; v++) begin
      rate_sel = V_SEL[v];
      tag = (V_SEL[v] == 2'b11) ? "R5" : "R4";
      for (int n = 0; n < V_CNT[v]; n++) begin
        wait_load(gap);
        check(gap == V_TC[v], {tag, " period"}, gap, V_TC[v]);
        check_load("R6");
      end
    end

    // R2: table points named in the requirement.
    check(exp_code(0) == 128 && exp_code(64) == 255 && exp_code(192) == 1,
          "R2 table points", exp_code(192), 1);
    while (held_phase != 63) begin
      wait_load(gap);
      check_load("R3");
    end
    wait_load(gap);
    check_load("R3");
    check(dac_code == 8'd255, "R2 index 64", int'(dac_code), 255);

    // R7: switch to a shorter count after the divider passed it.
    rate_sel = 2'b00;
    wait_load(gap);
    check_load("R6");
    idle(5);
    rate_sel = 2'b10;
    wait_load(gap);
    check(gap + 5 == 5 + 2, "R7 passed terminal", gap, 2);
    check_load("R7");

    // R7: switch while the divider is still below the new count.
    rate_sel = 2'b00;
    wait_load(gap);
    check(gap == T_A, "R4 after switch", gap, T_A);
    check_load("R6");
    idle(1);
    rate_sel = 2'b01;
    wait_load(gap);
    check(gap == T_B - 2 + 1, "R7 below terminal", gap, T_B - 1);
    check_load("R7");

    // R1: reset in mid-run.
    rst = 1'b1;
    @(negedge clk);
    check(phase == 8'd0 && dac_code == 8'd128 && !dac_load, "R1 mid-run reset",
          int'(phase), 0);
    rst = 1'b0;
    held_phase = 0;
    held_code  = 128;
    rate_sel = 2'b11;
    wait_load(gap);
    check(gap == T_A + 1, "R5 first load after reset", gap, T_A + 1);
    check_load("R1");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule